// File: doc/BRIEF.md
# Fixed-Program Register-Indirect Machine

A small multi-cycle processor that runs a program held in its own instruction store and keeps all of its data in a register file. There is no accumulator. Each instruction names up to three registers, or one register and a 16-bit constant. The program can only be loaded while reset is held. Once reset is released, execution starts at instruction slot 1. The program cannot be changed while it runs, and data writes never reach the instruction store.

Every data word is a 16-bit two's-complement register, and the file holds 64 of them. Arithmetic wraps modulo 2^16. Two move instructions use a register's contents as an address: one for the source, the other for the destination. A negative address stops the machine quietly. An address at or above the register count stops it and raises the error flag. Input is read through a valid/ready handshake, and output is announced with a one-cycle strobe. The machine stops when it fetches an empty or unassigned instruction slot, or when the program counter leaves the instruction store.

The control unit walks through these states:
- FETCH loads the instruction register and always moves on to EXEC.
- EXEC executes the instruction. It returns to FETCH after a constant load, add, subtract, jump or output. It goes to INDIR for an indirect move with a legal address, and to WAIT_IN for a read. It goes to HALT for an empty or unassigned opcode, or for a bad indirect address.
- INDIR completes the indirect access and returns to FETCH.
- WAIT_IN holds until input is offered, then returns to FETCH.
- HALT is never left until reset.

Top module: `regmach_core`

## Requirements
- R1: Program-store writes (`prog_we`, `prog_addr`, `prog_data`) take effect only while `rst_n` is low. A write attempted while running has no effect on execution.
- R2: Instruction word layout:
  - opcode in [31:28], with 1 constant load, 2 add, 3 subtract, 4 indirect-source move, 5 indirect-destination move, 6 jump-if-positive, 7 read, 8 print;
  - register fields i in [27:22], j in [21:16] and k in [15:10];
  - constant or jump target in [15:0].
  
  Execution starts at slot 1 and advances one slot per instruction unless a jump is taken.
- R3: While and after reset, all 64 registers read as zero, and `out_valid`, `err`, `halted` and `in_ready` are low during reset.
- R4: Constant load writes the 16-bit constant into Xi.
- R5: Add writes Xj+Xk into Xi and subtract writes Xj−Xk into Xi, both wrapping modulo 2^16.
- R6: Indirect-source move copies into Xi the register whose address is the value in Xj.
- R7: Indirect-destination move writes Xj into the register whose address is the value in Xi.
- R8: Jump-if-positive loads the target into the program counter only when Xj is strictly greater than zero (signed). A zero or negative Xj falls through.
- R9: Read raises `in_ready` and stalls until `in_valid` is high, then stores `in_data` into Xi and drops `in_ready`.
- R10: Print drives Xi on `out_data` with `out_valid` high for exactly one cycle.
- R11: Opcode 0 or any opcode above 8, or a program counter at or beyond the store depth, halts the machine. `halted` then stays high until reset and no further output or input request occurs.
- R12: A negative indirect address halts without setting `err`. A non-negative address at or above 64 sets `err` and halts. `err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; program loading window |
| prog_we | input | 1 | Program-store write enable (honoured only in reset) |
| prog_addr | input | 6 | Program-store slot to write |
| prog_data | input | 32 | Instruction word to write |
| in_valid | input | 1 | Input value offered |
| in_data | input | 16 | Input value |
| in_ready | output | 1 | Machine waiting in a read |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 16 | Output value, valid with the strobe |
| halted | output | 1 | Machine has stopped |
| err | output | 1 | Stopped on an out-of-range indirect address |

## Verification
The assertions take the following for granted:
- `in_valid` is only meaningful while `in_ready` is high, and the environment never withdraws reset mid-program.
- The program store was fully written during reset, so every fetched slot holds a defined word.

The stimulus keeps within this. Each program is loaded into all 64 slots before reset is released. Input is offered only after `in_ready` has been seen high for several cycles, and it is dropped the cycle after acceptance.

// File: rtl/regmach_pkg.sv
package regmach_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NONE = 4'd0,
        OP_LOD  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_MVS  = 4'd4,
        OP_MVD  = 4'd5,
        OP_JPOS = 4'd6,
        OP_RD   = 4'd7,
        OP_PRI  = 4'd8
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_INDIR,
        ST_WAIT_IN,
        ST_HALT
    } state_e;

endpackage

// File: rtl/regmach_imem.sv
module regmach_imem #(
    parameter int INSTR_W = 32,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_we,
    input  logic [AW-1:0]      ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [INSTR_W-1:0] rd_data
);

    logic [INSTR_W-1:0] slots [DEPTH];

    // Loading is only possible while the machine is held in reset.
    always_ff @(posedge clk) begin
        if (ld_we && !rst_n) begin
            slots[ld_addr] <= ld_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/regmach_regfile.sv
module regmach_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 64,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);

    logic [DW-1:0] words [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic [DW-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                word_q <= wr_data;
            end
        end

        assign words[g] = word_q;
    end

    assign ra_data = words[ra_addr];
    assign rb_data = words[rb_addr];

endmodule

// File: rtl/regmach_alu.sv
module regmach_alu #(
    parameter int DW   = 16,
    parameter int NREG = 64
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          do_sub,
    output logic [DW-1:0] result,
    output logic          opa_pos,
    output logic          opa_neg,
    output logic          opa_oob
);

    // Wraps modulo 2^DW by construction of the DW-bit result.
    assign result  = do_sub ? (opa - opb) : (opa + opb);
    assign opa_neg = opa[DW-1];
    assign opa_pos = !opa[DW-1] && (opa != '0);
    assign opa_oob = !opa[DW-1] && (opa >= DW'(NREG));

endmodule

// File: rtl/regmach_ctrl.sv
module regmach_ctrl
    import regmach_pkg::*;
#(
    parameter int DW         = 16,
    parameter int NREG       = 64,
    parameter int PROG_DEPTH = 64,
    parameter int INSTR_W    = 32,
    localparam int RA_W      = $clog2(NREG),
    localparam int IA_W      = $clog2(PROG_DEPTH),
    localparam int I_HI      = INSTR_W - OPC_W - 1,
    localparam int J_HI      = I_HI - RA_W,
    localparam int K_HI      = J_HI - RA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    // instruction store
    output logic [IA_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    // register file
    output logic [RA_W-1:0]    ra_addr,
    input  logic [DW-1:0]      ra_data,
    output logic [RA_W-1:0]    rb_addr,
    input  logic [DW-1:0]      rb_data,
    output logic               rf_we,
    output logic [RA_W-1:0]    rf_wa,
    output logic [DW-1:0]      rf_wd,
    // arithmetic unit
    output logic               alu_sub,
    input  logic [DW-1:0]      alu_res,
    input  logic               alu_pos,
    input  logic               alu_neg,
    input  logic               alu_oob,
    // block edge
    input  logic               in_valid,
    input  logic [DW-1:0]      in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [DW-1:0]      out_data,
    output logic               halted,
    output logic               err
);

    state_e               state_q, state_d;
    logic [DW-1:0]        pc_q;
    logic [INSTR_W-1:0]   ir_q;
    logic [RA_W-1:0]      ptr_q;
    logic [DW-1:0]        val_q;

    logic [OPC_W-1:0]     op;
    logic [RA_W-1:0]      fld_i, fld_j, fld_k;
    logic [DW-1:0]        fld_c;
    logic                 pc_in_store;
    logic                 is_indirect;

    assign op     = ir_q[INSTR_W-1 -: OPC_W];
    assign fld_i  = ir_q[I_HI -: RA_W];
    assign fld_j  = ir_q[J_HI -: RA_W];
    assign fld_k  = ir_q[K_HI -: RA_W];
    assign fld_c  = ir_q[DW-1:0];

    assign pc_in_store = (pc_q < DW'(PROG_DEPTH));
    assign imem_addr   = pc_q[IA_W-1:0];
    assign is_indirect = (op == OP_MVS) || (op == OP_MVD);
    assign alu_sub     = (op == OP_SUB);

    // Port A reads the pointer or single operand; port B the second operand.
    always_comb begin
        if (state_q == ST_INDIR) begin
            ra_addr = ptr_q;
        end else if ((op == OP_MVD) || (op == OP_PRI)) begin
            ra_addr = fld_i;
        end else begin
            ra_addr = fld_j;
        end
        rb_addr = (op == OP_MVD) ? fld_j : fld_k;
    end

    // Next state and register-file write control.
    always_comb begin
        state_d = state_q;
        rf_we   = 1'b0;
        rf_wa   = fld_i;
        rf_wd   = alu_res;
        unique case (state_q)
            ST_FETCH: begin
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                case (op)
                    OP_LOD: begin
                        rf_we   = 1'b1;
                        rf_wd   = fld_c;
                        state_d = ST_FETCH;
                    end
                    OP_ADD, OP_SUB: begin
                        rf_we   = 1'b1;
                        state_d = ST_FETCH;
                    end
                    OP_MVS, OP_MVD: begin
                        state_d = (alu_neg || alu_oob) ? ST_HALT : ST_INDIR;
                    end
                    OP_JPOS, OP_PRI: begin
                        state_d = ST_FETCH;
                    end
                    OP_RD: begin
                        state_d = ST_WAIT_IN;
                    end
                    default: begin
                        state_d = ST_HALT;
                    end
                endcase
            end
            ST_INDIR: begin
                rf_we   = 1'b1;
                state_d = ST_FETCH;
                if (op == OP_MVS) begin
                    rf_wa = fld_i;
                    rf_wd = ra_data;
                end else begin
                    rf_wa = ptr_q;
                    rf_wd = val_q;
                end
            end
            ST_WAIT_IN: begin
                if (in_valid) begin
                    rf_we   = 1'b1;
                    rf_wd   = in_data;
                    state_d = ST_FETCH;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

    // State register and sequencing datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= DW'(1);
            ir_q    <= '0;
            ptr_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH) begin
                ir_q <= pc_in_store ? imem_data : '0;
            end
            if (state_q == ST_EXEC) begin
                if ((op == OP_JPOS) && alu_pos) begin
                    pc_q <= fld_c;
                end else begin
                    pc_q <= pc_q + DW'(1);
                end
                if (is_indirect) begin
                    ptr_q <= ra_data[RA_W-1:0];
                    val_q <= rb_data;
                end
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= (state_q == ST_EXEC) && (op == OP_PRI);
            if ((state_q == ST_EXEC) && (op == OP_PRI)) begin
                out_data <= ra_data;
            end
            if ((state_q == ST_EXEC) && is_indirect && alu_oob) begin
                err <= 1'b1;
            end
        end
    end

    assign in_ready = (state_q == ST_WAIT_IN);
    assign halted   = (state_q == ST_HALT);

endmodule

// File: rtl/regmach_core.sv
module regmach_core #(
    parameter int DATA_W     = 16,
    parameter int NUM_REGS   = 64,
    parameter int PROG_DEPTH = 64,
    parameter int INSTR_W    = 32,
    localparam int REG_AW    = $clog2(NUM_REGS),
    localparam int PROG_AW   = $clog2(PROG_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PROG_AW-1:0] prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               halted,
    output logic               err
);

    logic [PROG_AW-1:0] imem_addr;
    logic [INSTR_W-1:0] imem_data;
    logic [REG_AW-1:0]  ra_addr, rb_addr, rf_wa;
    logic [DATA_W-1:0]  ra_data, rb_data, rf_wd;
    logic               rf_we;
    logic               alu_sub, alu_pos, alu_neg, alu_oob;
    logic [DATA_W-1:0]  alu_res;

    regmach_imem #(.INSTR_W(INSTR_W), .DEPTH(PROG_DEPTH)) u_imem (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (prog_we),
        .ld_addr (prog_addr),
        .ld_data (prog_data),
        .rd_addr (imem_addr),
        .rd_data (imem_data)
    );

    regmach_regfile #(.DW(DATA_W), .NREG(NUM_REGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data),
        .wr_en   (rf_we),
        .wr_addr (rf_wa),
        .wr_data (rf_wd)
    );

    regmach_alu #(.DW(DATA_W), .NREG(NUM_REGS)) u_alu (
        .opa     (ra_data),
        .opb     (rb_data),
        .do_sub  (alu_sub),
        .result  (alu_res),
        .opa_pos (alu_pos),
        .opa_neg (alu_neg),
        .opa_oob (alu_oob)
    );

    regmach_ctrl #(
        .DW(DATA_W), .NREG(NUM_REGS), .PROG_DEPTH(PROG_DEPTH), .INSTR_W(INSTR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .ra_addr   (ra_addr),
        .ra_data   (ra_data),
        .rb_addr   (rb_addr),
        .rb_data   (rb_data),
        .rf_we     (rf_we),
        .rf_wa     (rf_wa),
        .rf_wd     (rf_wd),
        .alu_sub   (alu_sub),
        .alu_res   (alu_res),
        .alu_pos   (alu_pos),
        .alu_neg   (alu_neg),
        .alu_oob   (alu_oob),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .err       (err)
    );

endmodule

// File: rtl/regmach_checker.sv
module regmach_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic halted,
    input logic err
);

    // R3: outputs are quiet while reset is held
    assert_reset_quiet_R3: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !err && !halted && !in_ready));

    assert_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    assert_read_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> !in_ready);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!out_valid && !in_ready));

    assert_err_halts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> halted);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

bind regmach_core regmach_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .halted    (halted),
    .err       (err)
);

// File: tb/test_regmach_core.sv
module test_regmach_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, halted, err;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [15:0] exp_q [$];
    logic [31:0] prog [64];

    always #2 clk = ~clk;

    regmach_core i_regmach_core (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .halted(halted), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            finish_run();
        end
    end

    // Scoreboard monitor: compares every strobe against the expected queue (R10).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected output", {16'h0, out_data}, 32'hDEAD_BEEF);
            end else begin
                check("R10 output value", {16'h0, out_data}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    function automatic logic [31:0] w_lod(input int i, input int c);
        return {4'd1, 6'(i), 6'd0, 16'(c)};
    endfunction
    function automatic logic [31:0] w_r3(input int op, input int i, input int j, input int k);
        return {4'(op), 6'(i), 6'(j), 6'(k), 10'd0};
    endfunction
    function automatic logic [31:0] w_jpos(input int j, input int m);
        return {4'd6, 6'd0, 6'(j), 16'(m)};
    endfunction

    task automatic expect_out(input int v);
        exp_q.push_back(16'(v));
    endtask

    task automatic clear_prog();
        for (int s = 0; s < 64; s++) prog[s] = '0;
    endtask

    // Holds reset, loads every slot, checks the reset outputs, releases.
    task automatic load_and_start();
        @(negedge clk);
        rst_n = 1'b0;
        for (int s = 0; s < 64; s++) begin
            prog_we   = 1'b1;
            prog_addr = 6'(s);
            prog_data = prog[s];
            @(negedge clk);
        end
        prog_we = 1'b0;
        check("R3 reset out_valid", {31'h0, out_valid}, 0);
        check("R3 reset err", {31'h0, err}, 0);
        check("R3 reset halted", {31'h0, halted}, 0);
        check("R3 reset in_ready", {31'h0, in_ready}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req, input logic exp_err);
        for (int t = 0; t < 3000 && !halted; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        check({req, " halted"}, {31'h0, halted}, 1);
        check({req, " err"}, {31'h0, err}, {31'h0, exp_err});
        check({req, " all outputs seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        // Program A: arithmetic, moves, loop, read (R2 R4 R5 R6 R7 R8 R9)
        clear_prog();
        prog[1]  = w_lod(1, 5);
        prog[2]  = w_lod(2, -3);
        prog[3]  = w_r3(2, 3, 1, 2);
        prog[4]  = w_r3(3, 4, 2, 1);
        prog[5]  = w_r3(8, 3, 0, 0);
        prog[6]  = w_r3(8, 4, 0, 0);
        prog[7]  = w_lod(5, 32767);
        prog[8]  = w_lod(6, 1);
        prog[9]  = w_r3(2, 7, 5, 6);
        prog[10] = w_r3(8, 7, 0, 0);
        prog[11] = w_r3(8, 9, 0, 0);
        prog[12] = w_lod(10, 3);
        prog[13] = w_r3(4, 11, 10, 0);
        prog[14] = w_r3(8, 11, 0, 0);
        prog[15] = w_lod(12, 20);
        prog[16] = w_r3(5, 12, 1, 0);
        prog[17] = w_r3(8, 20, 0, 0);
        prog[18] = w_lod(13, 3);
        prog[19] = w_lod(14, 1);
        prog[20] = w_r3(8, 13, 0, 0);
        prog[21] = w_r3(3, 13, 13, 14);
        prog[22] = w_jpos(13, 20);
        prog[23] = w_r3(7, 15, 0, 0);
        prog[24] = w_r3(8, 15, 0, 0);
        prog[25] = w_r3(2, 16, 15, 15);
        prog[26] = w_r3(8, 16, 0, 0);
        prog[27] = w_lod(17, 63);
        prog[28] = w_r3(5, 17, 1, 0);
        prog[29] = w_r3(8, 63, 0, 0);
        expect_out(2);       // R5 add
        expect_out(-8);      // R5 subtract
        expect_out(-32768);  // R5 wrap
        expect_out(0);       // R3 register zero after reset
        expect_out(2);       // R6 indirect source
        expect_out(5);       // R7 indirect destination
        expect_out(3); expect_out(2); expect_out(1); // R8 loop
        expect_out(-7);      // R9 read value
        expect_out(-14);     // R5 add of read value
        expect_out(5);       // R7 highest register index
        load_and_start();
        for (int t = 0; t < 3000 && !in_ready; t++) @(negedge clk);
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            check("R9 stall holds in_ready", {31'h0, in_ready}, 1);
        end
        in_valid = 1'b1;
        in_data  = 16'hFFF9;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 in_ready drops after accept", {31'h0, in_ready}, 0);
        wait_halt("R11 empty slot", 1'b0);

        // Program B: negative indirect address halts quietly (R12)
        clear_prog();
        prog[1] = w_lod(1, -1);
        prog[2] = w_r3(4, 2, 1, 0);
        prog[3] = w_r3(8, 0, 0, 0);
        load_and_start();
        wait_halt("R12 negative pointer", 1'b0);

        // Program C: out-of-range indirect address raises err (R12)
        clear_prog();
        prog[1] = w_lod(1, 64);
        prog[2] = w_r3(8, 1, 0, 0);
        prog[3] = w_r3(5, 1, 0, 0);
        prog[4] = w_r3(8, 0, 0, 0);
        expect_out(64);
        load_and_start();
        wait_halt("R12 pointer out of range", 1'b1);

        // Program D: jump conditions, unassigned opcode, runtime load ignored (R1 R8 R11)
        clear_prog();
        prog[1]  = w_lod(1, 7);
        prog[2]  = w_lod(2, -1);
        prog[3]  = w_jpos(2, 9);
        prog[4]  = w_jpos(1, 7);
        prog[5]  = w_r3(8, 2, 0, 0);
        prog[6]  = w_r3(8, 2, 0, 0);
        prog[7]  = w_r3(8, 1, 0, 0);
        prog[8]  = {4'd15, 28'd0};
        prog[9]  = w_r3(8, 2, 0, 0);
        prog[10] = w_r3(8, 1, 0, 0);
        expect_out(7);
        load_and_start();
        prog_we   = 1'b1;          // R1: write while running must be ignored
        prog_addr = 6'd8;
        prog_data = w_r3(8, 1, 0, 0);
        @(negedge clk);
        prog_we = 1'b0;
        wait_halt("R11 unassigned opcode R1", 1'b0);

        // Program E: jump beyond the store halts (R11)
        clear_prog();
        prog[1] = w_lod(1, 1);
        prog[2] = w_jpos(1, 100);
        prog[3] = w_r3(8, 1, 0, 0);
        load_and_start();
        wait_halt("R11 pc beyond store", 1'b0);
        repeat (10) @(negedge clk);
        check("R11 halted stays", {31'h0, halted}, 1);

        finish_run();
    end

endmodule